// File: doc/BRIEF.md
# Latched parallel-to-serial converter

This block holds a parallel word in a holding register and then sends it out one bit at a time through a separate shift chain. The holding register takes the parallel inputs on each rising edge of its own capture strobe. The shift chain is controlled by three inputs. An active-low clear empties it. An active-low transfer copies the holding register into it. Rising edges of a shift strobe move the contents one stage towards the output, and each edge brings a new bit in from the serial input. The serial output is always the last stage of the chain.

Both strobes are treated as ordinary inputs and are not used as clocks. The capture strobe, the shift strobe, the transfer level and the clear level all pass through the same synchronizer depth into a single system clock domain. Because of this, their order relative to one another is kept. A strobe edge is found by comparing the synchronized value with the value it had one system cycle earlier. Clear and transfer are levels that are looked at in every system cycle, in the order clear, then transfer, then shift. The system reset is asserted asynchronously and released in step with the system clock.

Top module: `latshift_top`

## Requirements
- R1: On a detected rising edge of `cap_strobe`, the holding register takes `par_in`. Bit 0 of `par_in` is the first-stage value and bit WIDTH-1 is the last-stage value.
- R2: The holding register changes only on a capture edge. Clear, transfer and shift activity never alter it.
- R3: While `clear_n` is low, the shift chain is all zeros. The transfer level, shift edges and `ser_in` have no effect during this time.
- R4: While `clear_n` is high and `xfer_n` is low, the shift chain equals the holding register, and shift edges are ignored.
- R5: With `clear_n` and `xfer_n` both high, each detected rising edge of `shift_strobe` puts `ser_in` into stage 0, and every other stage takes the value of the stage below it.
- R6: With `clear_n` and `xfer_n` both high and no shift edge, the shift chain keeps its value.
- R7: `ser_out` is stage WIDTH-1. After a transfer, it shows bit WIDTH-1 first, and the next WIDTH-1 shift edges show the bits below it in descending order.
- R8: If a capture edge happens while the transfer level is held low, the new word enters the shift chain in the same system cycle in which the holding register updates.
- R9: The four control inputs pass through SYNC_STAGES flip-flops. Each control takes effect a fixed number of system cycles after it changes, and this number is the same for all four.
- R10: After reset, both registers hold zero and `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| par_in | input | WIDTH | Parallel word; bit 0 feeds stage 0 |
| cap_strobe | input | 1 | Holding-register capture strobe (acts on its rising edge) |
| shift_strobe | input | 1 | Shift strobe (acts on its rising edge) |
| xfer_n | input | 1 | Active-low transfer level, holding register into shift chain |
| clear_n | input | 1 | Active-low clear level for the shift chain |
| ser_in | input | 1 | Serial bit entering stage 0 |
| ser_out | output | 1 | Last stage of the shift chain |

## Verification
Three pairs of controls can take effect in the same system cycle. The first pair is a shift edge or transfer arriving while clear is held low. The second is a shift edge arriving while transfer is held low. The third is a capture edge arriving while transfer is held low. The bench sets up each case by holding the overriding level low across the other event. It then releases the controls and shifts the whole chain out through `ser_out`. The result is compared with a reference model of both registers that applies the priority clear, then transfer, then shift. A seeded random run of captures, transfers, clears and shifts compares `ser_out` after every operation.

// File: rtl/latshift_pkg.sv
package latshift_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_XFER  = 2'd2,
    OP_SHIFT = 2'd3
  } chain_op_e;

  // bit positions inside the synchronized control vector
  localparam int unsigned CTL_CAP   = 0;
  localparam int unsigned CTL_SHIFT = 1;
  localparam int unsigned CTL_XFER  = 2;
  localparam int unsigned CTL_CLEAR = 3;
  localparam int unsigned CTL_W     = 4;

endpackage

// File: rtl/latshift_rst_sync.sv
module latshift_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/latshift_ctl_sync.sv
module latshift_ctl_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = async_in;
    end else begin : g_rest
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];

  // R9: each output follows the input exactly STAGES cycles later
  // (checked per stage so the window never grows with the parameter)
  for (genvar s = 1; s < STAGES; s++) begin : g_chk
    assert_sync_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stage_q[s] == $past(stage_q[s-1]));
  end
endmodule

// File: rtl/latshift_rise.sv
module latshift_rise #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_in,
  output logic [N-1:0] rise_out
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb prev_d = level_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise_out[i] = level_in[i] & ~prev_q[i];
  end

  // R9: a rise lasts one cycle only
  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_out[i] |=> !rise_out[i]);
  end
endmodule

// File: rtl/latshift_hold_reg.sv
module latshift_hold_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_rise,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] hold_q,
  output logic [WIDTH-1:0] hold_nxt
);
  logic cap_en;

  always_comb begin
    cap_en   = cap_rise;
    hold_nxt = cap_en ? par_in : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (cap_en) hold_q <= hold_nxt;
  end

  assert_hold_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> hold_q == $past(par_in));

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise |=> $stable(hold_q));
endmodule

// File: rtl/latshift_chain.sv
module latshift_chain
  import latshift_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_lvl_n,
  input  logic             xfer_lvl_n,
  input  logic             shift_rise,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] chain_q
);
  chain_op_e        op;
  logic [WIDTH-1:0] chain_d;
  logic             chain_en;

  always_comb begin
    if (!clear_lvl_n)     op = OP_CLEAR;
    else if (!xfer_lvl_n) op = OP_XFER;
    else if (shift_rise)  op = OP_SHIFT;
    else                  op = OP_HOLD;
  end

  always_comb begin
    chain_en = (op != OP_HOLD);
    unique case (op)
      OP_CLEAR: chain_d = '0;
      OP_XFER:  chain_d = load_val;
      OP_SHIFT: chain_d = {chain_q[WIDTH-2:0], ser_in};
      default:  chain_d = chain_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (chain_en) chain_q <= chain_d;
  end

  assert_chain_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_lvl_n |=> chain_q == '0);

  assert_chain_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_lvl_n && !xfer_lvl_n) |=> chain_q == $past(load_val));

  assert_chain_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_lvl_n && xfer_lvl_n && shift_rise)
      |=> chain_q == {$past(chain_q[WIDTH-2:0]), $past(ser_in)});

  assert_chain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_lvl_n && xfer_lvl_n && !shift_rise) |=> $stable(chain_q));
endmodule

// File: rtl/latshift_top.sv
module latshift_top
  import latshift_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_strobe,
  input  logic             shift_strobe,
  input  logic             xfer_n,
  input  logic             clear_n,
  input  logic             ser_in,
  output logic             ser_out
);
  localparam logic [CTL_W-1:0] CTL_RST = 4'b1100;  // levels idle high, strobes low

  logic             rst_core_n;
  logic [CTL_W-1:0] ctl_raw;
  logic [CTL_W-1:0] ctl_sync;
  logic [1:0]       strobe_rise;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_nxt;
  logic [WIDTH-1:0] chain_q;

  always_comb begin
    ctl_raw            = '0;
    ctl_raw[CTL_CAP]   = cap_strobe;
    ctl_raw[CTL_SHIFT] = shift_strobe;
    ctl_raw[CTL_XFER]  = xfer_n;
    ctl_raw[CTL_CLEAR] = clear_n;
  end

  latshift_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n));

  latshift_ctl_sync #(.N(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .async_in(ctl_raw), .sync_out(ctl_sync));

  latshift_rise #(.N(2)) u_rise (
    .clk(clk), .rst_n(rst_core_n),
    .level_in({ctl_sync[CTL_SHIFT], ctl_sync[CTL_CAP]}),
    .rise_out(strobe_rise));

  latshift_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_core_n), .cap_rise(strobe_rise[0]),
    .par_in(par_in), .hold_q(hold_q), .hold_nxt(hold_nxt));

  latshift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(clk), .rst_n(rst_core_n),
    .clear_lvl_n(ctl_sync[CTL_CLEAR]), .xfer_lvl_n(ctl_sync[CTL_XFER]),
    .shift_rise(strobe_rise[1]), .ser_in(ser_in),
    .load_val(hold_nxt), .chain_q(chain_q));

  assign ser_out = chain_q[WIDTH-1];

  // R8: capture under a held transfer reaches the chain together with the holding register
  assert_xfer_tracks_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctl_sync[CTL_CLEAR] && !ctl_sync[CTL_XFER]) |=> chain_q == hold_q);

  // R10: while the core is held in reset the output is low
  always_comb begin
    if (!rst_core_n) assert_reset_out_R10: assert (ser_out == 1'b0);
  end
endmodule

// File: tb/latshift_top_tb_top.sv
module latshift_top_tb_top;
  localparam int W = 8;
  localparam int SETTLE = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] par_in;
  logic         cap_strobe, shift_strobe, xfer_n, clear_n, ser_in;
  logic         ser_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_hold, m_chain;
  logic         m_clear_n, m_xfer_n;

  always #4 clk = ~clk;

  latshift_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_strobe(cap_strobe),
    .shift_strobe(shift_strobe), .xfer_n(xfer_n), .clear_n(clear_n),
    .ser_in(ser_in), .ser_out(ser_out));

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of the chain given the current levels
  function automatic void apply_levels();
    if (!m_clear_n)     m_chain = '0;
    else if (!m_xfer_n) m_chain = m_hold;
  endfunction

  task automatic set_levels(input logic clr_n, input logic xf_n);
    clear_n = clr_n; xfer_n = xf_n;
    m_clear_n = clr_n; m_xfer_n = xf_n;
    wait_cyc(SETTLE);
    apply_levels();
  endtask

  task automatic cap_pulse(input logic [W-1:0] d);
    par_in = d; cap_strobe = 1'b1;
    wait_cyc(SETTLE);
    m_hold = d;
    apply_levels();
    cap_strobe = 1'b0;
    wait_cyc(SETTLE);
  endtask

  task automatic shift_pulse(input logic b);
    ser_in = b; shift_strobe = 1'b1;
    wait_cyc(SETTLE);
    if (m_clear_n && m_xfer_n) m_chain = {m_chain[W-2:0], b};
    apply_levels();
    shift_strobe = 1'b0;
    wait_cyc(SETTLE);
  endtask

  task automatic xfer_pulse();
    set_levels(1'b1, 1'b0);
    set_levels(1'b1, 1'b1);
  endtask

  // shifts the whole chain out, comparing each bit with the model (R7)
  task automatic drain(input string req);
    for (int i = 0; i < W; i++) begin
      chk(req, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_chain[W-1]});
      shift_pulse(1'b0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; par_in = '0; cap_strobe = 0; shift_strobe = 0;
    xfer_n = 1; clear_n = 1; ser_in = 0;
    m_hold = '0; m_chain = '0; m_clear_n = 1; m_xfer_n = 1;
    wait_cyc(5);
    chk("R10 out in reset", {{(W-1){1'b0}}, ser_out}, '0);
    rst_n = 1'b1;
    wait_cyc(6);
    chk("R10 out after reset", {{(W-1){1'b0}}, ser_out}, '0);
    xfer_pulse();
    drain("R10 holding register zero");
  endtask

  task automatic t_order();
    logic [W-1:0] got;
    cap_pulse(8'b1011_0010);
    xfer_pulse();
    for (int i = 0; i < W; i++) begin
      got[W-1-i] = ser_out;
      shift_pulse(1'b1);
    end
    chk("R7 bit order H..A after transfer (R1 R5)", got, 8'b1011_0010);
    drain("R5 serial input fill with ones");
  endtask

  task automatic t_hold_isolated();
    cap_pulse(8'h5C);
    set_levels(1'b0, 1'b1);
    shift_pulse(1'b1);
    set_levels(1'b1, 1'b1);
    shift_pulse(1'b1);
    shift_pulse(1'b0);
    chk("R2 chain after shifts", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_chain[W-1]});
    xfer_pulse();
    drain("R2 holding register unchanged by clear and shift");
  endtask

  task automatic t_clear_during_xfer();
    cap_pulse(8'hFF);
    set_levels(1'b0, 1'b0);
    chk("R3 clear beats transfer", {{(W-1){1'b0}}, ser_out}, '0);
    shift_pulse(1'b1);
    chk("R3 clear ignores shift and ser_in", {{(W-1){1'b0}}, ser_out}, '0);
    set_levels(1'b1, 1'b0);
    chk("R4 transfer after clear release", {{(W-1){1'b0}}, ser_out}, 1);
    set_levels(1'b1, 1'b1);
    drain("R4 chain equals holding register");
    set_levels(1'b0, 1'b1);
    set_levels(1'b1, 1'b1);
    drain("R3 clear empties chain");
  endtask

  task automatic t_shift_during_xfer();
    cap_pulse(8'h01);
    set_levels(1'b1, 1'b0);
    shift_pulse(1'b1);
    shift_pulse(1'b1);
    chk("R4 shift ignored under transfer", {{(W-1){1'b0}}, ser_out}, '0);
    set_levels(1'b1, 1'b1);
    drain("R4 chain unchanged by shift edges");
  endtask

  task automatic t_cap_during_xfer();
    cap_pulse(8'h00);
    set_levels(1'b1, 1'b0);
    cap_pulse(8'h93);
    chk("R8 new capture visible under transfer", {{(W-1){1'b0}}, ser_out}, 1);
    set_levels(1'b1, 1'b1);
    drain("R8 chain holds captured word");
  endtask

  task automatic t_idle_hold();
    cap_pulse(8'hA6);
    xfer_pulse();
    par_in = 8'h3F; ser_in = 1'b1;
    wait_cyc(40);
    drain("R6 chain held with no shift edge");
  endtask

  task automatic t_random();
    void'($urandom(32'd77));
    for (int k = 0; k < 60; k++) begin
      int sel;
      sel = $urandom_range(0, 3);
      case (sel)
        0: cap_pulse(W'($urandom));
        1: xfer_pulse();
        2: begin set_levels(1'b0, 1'b1); set_levels(1'b1, 1'b1); end
        default: shift_pulse(1'($urandom));
      endcase
      chk("R5 random sequence ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_chain[W-1]});
    end
    drain("R7 random sequence final contents");
  endtask

  initial begin
    t_reset();
    t_order();
    t_hold_isolated();
    t_clear_during_xfer();
    t_shift_during_xfer();
    t_cap_during_xfer();
    t_idle_hold();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule